// File: doc/BRIEF.md
# Interrupt Message Source with End-of-Interrupt Handshake

This block turns a set of level-sensitive interrupt lines into interrupt request messages. Each source owns a 64-bit definition entry. The entry holds a vector, a message type, a destination mode, a destination, an enable mask, an input polarity and an option to wait for an end-of-interrupt (EOI). Software reaches each entry as two 32-bit words through a plain register port. The port has a write strobe and a word address, and its read data is combinational.

Each input line passes through a two-flop synchronizer. The polarity bit then decides whether a high or a low level counts as active. A source is eligible when it is active and unmasked and is not stalled waiting for an EOI. A fixed-priority picker chooses the lowest-numbered eligible source. The chosen message is held in an output register and offered on a valid/ready handshake. When a source with the EOI option enabled has its message accepted, a read-only waiting flag is raised for it. That flag stops any further request from the source until an EOI strobe naming the source arrives.

Top module: `irq_msg_source`

## Requirements
- R1: Entry i is addressed as two words: the low word at word address 2*i and the high word at 2*i+1; what is written to a word's writable fields reads back unchanged.
- R2: After reset every low word reads 0x0001_0000 (mask bit 16 set, every other field zero), every high word reads 0, and no message is offered; a source whose mask bit 16 is 1 never produces a message.
- R3: When request-EOI (low word bit 15) is 1, a source that has had a message accepted produces no further message while its waiting flag is set, even if its line stays active.
- R4: The waiting flag (low word bit 14) ignores writes; it is set on the cycle a message from a source with request-EOI set is accepted, and cleared by an EOI strobe carrying that source's index.
- R5: Low word bit 13 selects polarity: 0 makes a high line active, 1 makes a low line active; an inactive line produces no message.
- R6: An EOI strobe changes only the waiting flag of the source it names, and has no effect if that flag is clear.
- R7: Low word bits 31:17 and 12 read as zero; the high word holds the 8-bit destination in bits 31:24; with wide destinations disabled (the default), high word bits 23:0 read as zero whatever is written.
- R8: A write of the low word with bit 15 at 0 also clears that source's waiting flag.
- R9: The message carries the vector (low bits 7:0), the type (low bits 10:8), the destination mode (low bit 11, 1 = logical), the destination, the extended destination and the source index; while valid is high and ready is low, it stays valid and unchanged.
- R10: When several sources are eligible together, messages leave in ascending order of source index.
- R11: With request-EOI at 0, a source whose line stays active produces a new message after each accepted one.
- R12: An EOI for one source and the acceptance of another source's message in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address (2*i low, 2*i+1 high) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_line | input | NUM_SRC | Asynchronous interrupt inputs |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_vector | output | 8 | Message vector |
| msg_type | output | 3 | Message type |
| msg_dest_logical | output | 1 | Destination mode, 1 = logical |
| msg_dest | output | 8 | Destination |
| msg_ext_dest | output | 24 | Extended destination |
| msg_src | output | SRC_W | Index of the source that raised the message |
| eoi_valid | input | 1 | EOI return strobe |
| eoi_src | input | SRC_W | Source index the EOI is meant for |

## Verification
Two functions can fall in the same cycle. The return of an EOI for one waiting source can coincide with the acceptance of another source's message, which raises that source's waiting flag. The bench stalls two EOI-enabled sources and then drives ready and an EOI for the lower source in one cycle. Both effects must land: the lower source must be offered again next, and readback must show the higher source's flag set and the lower one's clear. Randomised rounds check the priority order. Each round uses random polarities, masks and line levels, and all lines switch at once.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int unsigned DEST_W = 8;
    localparam int unsigned EXT_W  = 24;
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned TYPE_W = 3;

    // Bit positions inside the low word (software-visible layout)
    localparam int unsigned B_MASK  = 16;
    localparam int unsigned B_RQEOI = 15;
    localparam int unsigned B_WAIT  = 14;
    localparam int unsigned B_POL   = 13;
    localparam int unsigned B_DMODE = 11;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [EXT_W-1:0]  ext_dest;
        logic              mask;
        logic              rq_eoi;
        logic              waiting;
        logic              act_low;
        logic              dest_logical;
        logic [TYPE_W-1:0] mtype;
        logic [VEC_W-1:0]  vector;
    } irq_entry_t;

    localparam irq_entry_t ENTRY_RST = '{
        dest:         '0,
        ext_dest:     '0,
        mask:         1'b1,
        rq_eoi:       1'b0,
        waiting:      1'b0,
        act_low:      1'b0,
        dest_logical: 1'b0,
        mtype:        '0,
        vector:       '0
    };

    function automatic logic [31:0] pack_lo(input irq_entry_t e);
        logic [31:0] w;
        w          = '0;
        w[B_MASK]  = e.mask;
        w[B_RQEOI] = e.rq_eoi;
        w[B_WAIT]  = e.waiting;
        w[B_POL]   = e.act_low;
        w[B_DMODE] = e.dest_logical;
        w[10:8]    = e.mtype;
        w[7:0]     = e.vector;
        return w;
    endfunction

    function automatic logic [31:0] pack_hi(input irq_entry_t e);
        return {e.dest, e.ext_dest};
    endfunction

endpackage

// File: rtl/irq_msg_sync.sv
module irq_msg_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.stage2;

endmodule

// File: rtl/irq_msg_entry.sv
module irq_msg_entry
    import irq_msg_pkg::*;
#(
    parameter bit WIDE_DEST = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        sent,
    input  logic        eoi_hit,
    output irq_entry_t  entry_o
);

    irq_entry_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_lo) begin
            ent_d.mask         = wdata[B_MASK];
            ent_d.rq_eoi       = wdata[B_RQEOI];
            ent_d.act_low      = wdata[B_POL];
            ent_d.dest_logical = wdata[B_DMODE];
            ent_d.mtype        = wdata[10:8];
            ent_d.vector       = wdata[7:0];
        end
        if (wr_hi) begin
            ent_d.dest     = wdata[31:24];
            ent_d.ext_dest = WIDE_DEST ? wdata[23:0] : '0;
        end
        // Acceptance raises the flag; an EOI for this source lowers it.
        if (sent && ent_q.rq_eoi) begin
            ent_d.waiting = 1'b1;
        end else if (eoi_hit && ent_q.waiting) begin
            ent_d.waiting = 1'b0;
        end
        // Dropping the EOI option releases any stalled source.
        if (!ent_d.rq_eoi) begin
            ent_d.waiting = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= ENTRY_RST;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign entry_o = ent_q;

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb #(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        any   = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_msg_source.sv
module irq_msg_source
    import irq_msg_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 4,
    parameter bit          WIDE_DEST = 1'b0,
    localparam int unsigned SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int unsigned ADDR_W   = $clog2(2 * NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_SRC-1:0] irq_line,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_type,
    output logic              msg_dest_logical,
    output logic [7:0]        msg_dest,
    output logic [23:0]       msg_ext_dest,
    output logic [SRC_W-1:0]  msg_src,
    input  logic              eoi_valid,
    input  logic [SRC_W-1:0]  eoi_src
);

    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  src;
        logic [VEC_W-1:0]  vector;
        logic [TYPE_W-1:0] mtype;
        logic              dlog;
        logic [DEST_W-1:0] dest;
        logic [EXT_W-1:0]  ext;
    } out_t;

    irq_entry_t         ent [NUM_SRC];
    logic [NUM_SRC-1:0] wr_lo_vec, wr_hi_vec, sent_vec, eoi_vec;
    logic [NUM_SRC-1:0] mask_vec, rq_vec, wait_vec, pol_vec;
    logic [NUM_SRC-1:0] line_sync, active_vec, elig_vec, grant_vec;
    logic [SRC_W-1:0]   pick_idx;
    logic               pick_any;
    out_t               out_d, out_q;

    irq_msg_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_line),
        .sync_o  (line_sync)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign wr_lo_vec[i] = reg_wr && (reg_addr == ADDR_W'(2 * i));
        assign wr_hi_vec[i] = reg_wr && (reg_addr == ADDR_W'(2 * i + 1));
        assign sent_vec[i]  = out_q.valid && msg_ready && (out_q.src == SRC_W'(i));
        assign eoi_vec[i]   = eoi_valid && (eoi_src == SRC_W'(i));

        irq_msg_entry #(.WIDE_DEST(WIDE_DEST)) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (wr_lo_vec[i]),
            .wr_hi   (wr_hi_vec[i]),
            .wdata   (reg_wdata),
            .sent    (sent_vec[i]),
            .eoi_hit (eoi_vec[i]),
            .entry_o (ent[i])
        );

        assign mask_vec[i] = ent[i].mask;
        assign rq_vec[i]   = ent[i].rq_eoi;
        assign wait_vec[i] = ent[i].waiting;
        assign pol_vec[i]  = ent[i].act_low;
    end

    assign active_vec = line_sync ^ pol_vec;
    assign elig_vec   = active_vec & ~mask_vec & ~(rq_vec & wait_vec);

    irq_msg_arb #(.N(NUM_SRC), .IDX_W(SRC_W)) u_arb (
        .req   (elig_vec),
        .grant (grant_vec),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_addr == ADDR_W'(2 * i)) begin
                reg_rdata = pack_lo(ent[i]);
            end
            if (reg_addr == ADDR_W'(2 * i + 1)) begin
                reg_rdata = pack_hi(ent[i]);
            end
        end
    end

    always_comb begin
        out_d = out_q;
        if (out_q.valid && msg_ready) begin
            out_d.valid = 1'b0;
        end
        if (!out_q.valid && pick_any) begin
            out_d.valid  = 1'b1;
            out_d.src    = pick_idx;
            out_d.vector = ent[pick_idx].vector;
            out_d.mtype  = ent[pick_idx].mtype;
            out_d.dlog   = ent[pick_idx].dest_logical;
            out_d.dest   = ent[pick_idx].dest;
            out_d.ext    = ent[pick_idx].ext_dest;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign msg_valid        = out_q.valid;
    assign msg_src          = out_q.src;
    assign msg_vector       = out_q.vector;
    assign msg_type         = out_q.mtype;
    assign msg_dest_logical = out_q.dlog;
    assign msg_dest         = out_q.dest;
    assign msg_ext_dest     = out_q.ext;

endmodule

// File: rtl/irq_msg_source_chk.sv
module irq_msg_source_chk #(
    parameter int unsigned N     = 4,
    parameter int unsigned SRC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     elig_vec,
    input logic [N-1:0]     grant_vec,
    input logic [N-1:0]     mask_vec,
    input logic [N-1:0]     rq_vec,
    input logic [N-1:0]     wait_vec,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [SRC_W-1:0] msg_src,
    input logic [7:0]       msg_vector
);

    logic [N-1:0] mask_p, rq_p, wait_p;
    logic         valid_p, acc_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_p  <= '1;
            rq_p    <= '0;
            wait_p  <= '0;
            valid_p <= 1'b0;
            acc_p   <= 1'b0;
        end else begin
            mask_p  <= mask_vec;
            rq_p    <= rq_vec;
            wait_p  <= wait_vec;
            valid_p <= msg_valid;
            acc_p   <= msg_valid && msg_ready;
        end
    end

    p_grant_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec) && (grant_vec == (elig_vec & (~elig_vec + N'(1)))));

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_src) && $stable(msg_vector));

    p_load_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !valid_p |-> !mask_p[msg_src]);

    p_load_not_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !valid_p |-> !(wait_p[msg_src] && rq_p[msg_src]));

    p_wait_needs_rqeoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_vec & ~rq_vec) == '0);

    p_wait_rise_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_vec & ~wait_p) != '0 |-> acc_p);

endmodule

bind irq_msg_source irq_msg_source_chk #(.N(NUM_SRC), .SRC_W(SRC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .elig_vec   (elig_vec),
    .grant_vec  (grant_vec),
    .mask_vec   (mask_vec),
    .rq_vec     (rq_vec),
    .wait_vec   (wait_vec),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_src    (msg_src),
    .msg_vector (msg_vector)
);

// File: tb/irq_msg_source_bench.sv
`timescale 1ns/1ps
module irq_msg_source_bench;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] line = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_type;
    logic        msg_dest_logical;
    logic [23:0] msg_ext_dest;
    logic [1:0]  msg_src;
    logic        eoi_valid = 1'b0;
    logic [1:0]  eoi_src = '0;

    int n_cmp = 0;
    int n_bad = 0;

    int          got_n;
    int          got_src [64];
    logic [7:0]  got_vec [64];
    logic [2:0]  got_typ [64];
    logic        got_dl  [64];
    logic [7:0]  got_dst [64];
    logic [23:0] got_ext [64];

    always #2 clk = ~clk;

    irq_msg_source u_irq_msg_source (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_line(line),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_type(msg_type), .msg_dest_logical(msg_dest_logical),
        .msg_dest(msg_dest), .msg_ext_dest(msg_ext_dest), .msg_src(msg_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    function automatic logic [31:0] mk_lo(input logic msk, input logic rq, input logic pol,
                                          input logic dl, input logic [2:0] ty, input logic [7:0] vec);
        return {15'b0, msk, rq, 1'b0, pol, 1'b0, dl, ty, vec};
    endfunction

    function automatic logic [31:0] lo_exp(input logic [31:0] w, input logic wt);
        return (w & 32'h0001_AFFF) | (32'(wt) << 14);
    endfunction

    function automatic logic [31:0] hi_exp(input logic [31:0] w);
        return w & 32'hFF00_0000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic collect(input int cycles);
        got_n = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (msg_valid && msg_ready && got_n < 64) begin
                got_src[got_n] = int'(msg_src);
                got_vec[got_n] = msg_vector;
                got_typ[got_n] = msg_type;
                got_dl[got_n]  = msg_dest_logical;
                got_dst[got_n] = msg_dest;
                got_ext[got_n] = msg_ext_dest;
                got_n++;
            end
        end
    endtask

    task automatic eoi(input int s);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_src = 2'(s);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset values
        for (int i = 0; i < N; i++) begin
            rd(2 * i, d);     chk("R2 reset low word", d, 32'h0001_0000);
            rd(2 * i + 1, d); chk("R2 reset high word", d, 32'h0);
        end
        chk("R2 no message after reset", 32'(msg_valid), 32'h0);

        // R7: reserved bits and narrow destination
        line = 4'hF;
        repeat (4) @(negedge clk);
        wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R7 reserved low bits", d, 32'h0001_AFFF);
        wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R7 extended dest zero", d, 32'hFF00_0000);
        wr(0, 32'h0001_0000);

        // R1: random register traffic, all sources masked
        for (int k = 0; k < 40; k++) begin
            int s;
            logic [31:0] lo, hi;
            s  = int'($urandom % N);
            lo = $urandom | 32'h0001_0000;
            hi = $urandom;
            wr(2 * s + 1, hi);
            wr(2 * s, lo);
            rd(2 * s, d);     chk("R1 low word readback", d, lo_exp(lo, 1'b0));
            rd(2 * s + 1, d); chk("R1 high word readback", d, hi_exp(hi));
        end

        // R2/R9/R11: source 2, active-high, no EOI
        msg_ready = 1'b1;
        wr(4, mk_lo(1, 0, 0, 1, 3'd3, 8'h5A));
        collect(6);
        chk("R2 masked source silent", 32'(got_n), 32'd0);
        wr(5, 32'hC3FF_FFFF);
        wr(4, mk_lo(0, 0, 0, 1, 3'd3, 8'h5A));
        collect(12);
        chk("R11 repeated requests", 32'(got_n >= 2), 32'd1);
        chk("R9 source index", 32'(got_src[0]), 32'd2);
        chk("R9 vector", 32'(got_vec[0]), 32'h5A);
        chk("R9 type", 32'(got_typ[0]), 32'd3);
        chk("R9 dest mode", 32'(got_dl[0]), 32'd1);
        chk("R9 dest", 32'(got_dst[0]), 32'hC3);
        chk("R7 ext dest in message", 32'(got_ext[0]), 32'h0);
        wr(4, mk_lo(1, 0, 0, 1, 3'd3, 8'h5A));
        collect(3);
        collect(8);
        chk("R2 remasked source silent", 32'(got_n), 32'd0);

        // R5: source 1 active-low
        @(negedge clk); line[1] = 1'b0;
        repeat (3) @(negedge clk);
        wr(2, mk_lo(0, 0, 1, 0, 3'd0, 8'h11));
        collect(8);
        chk("R5 active-low request", 32'(got_n >= 1), 32'd1);
        chk("R5 source index", 32'(got_src[0]), 32'd1);
        @(negedge clk); line[1] = 1'b1;
        collect(5);
        collect(8);
        chk("R5 high level inactive", 32'(got_n), 32'd0);
        wr(2, mk_lo(1, 0, 1, 0, 3'd0, 8'h11));

        // R3/R4/R6/R8: source 3 with EOI handshake
        wr(6, mk_lo(0, 1, 0, 0, 3'd2, 8'h33));
        collect(10);
        chk("R3 single request while waiting", 32'(got_n), 32'd1);
        rd(6, d); chk("R4 waiting flag set", d, lo_exp(mk_lo(0, 1, 0, 0, 3'd2, 8'h33), 1'b1));
        wr(6, mk_lo(0, 1, 0, 0, 3'd2, 8'h33) | 32'h0000_4000);
        rd(6, d); chk("R4 waiting flag write ignored", d, lo_exp(mk_lo(0, 1, 0, 0, 3'd2, 8'h33), 1'b1));
        eoi(0);
        collect(6);
        chk("R6 foreign EOI no request", 32'(got_n), 32'd0);
        rd(6, d); chk("R6 foreign EOI keeps flag", d, lo_exp(mk_lo(0, 1, 0, 0, 3'd2, 8'h33), 1'b1));
        @(negedge clk); line[3] = 1'b0;
        repeat (4) @(negedge clk);
        eoi(3);
        rd(6, d); chk("R4 EOI clears flag", d, lo_exp(mk_lo(0, 1, 0, 0, 3'd2, 8'h33), 1'b0));
        eoi(3);
        rd(6, d); chk("R6 EOI with flag clear", d, lo_exp(mk_lo(0, 1, 0, 0, 3'd2, 8'h33), 1'b0));
        @(negedge clk); line[3] = 1'b1;
        collect(10);
        chk("R4 request after EOI", 32'(got_n), 32'd1);
        wr(6, mk_lo(1, 0, 0, 0, 3'd2, 8'h33));
        rd(6, d); chk("R8 clearing rqeoi clears flag", d, lo_exp(mk_lo(1, 0, 0, 0, 3'd2, 8'h33), 1'b0));

        // R12: EOI and acceptance in the same cycle
        msg_ready = 1'b0;
        wr(0, mk_lo(0, 1, 0, 0, 3'd0, 8'hA0));
        wr(2, mk_lo(0, 1, 0, 0, 3'd0, 8'hB1));
        repeat (3) @(negedge clk);
        chk("R9 held while stalled", {msg_valid, 22'b0, msg_vector, msg_src}, {1'b1, 22'b0, 8'hA0, 2'd0});
        msg_ready = 1'b1;
        @(negedge clk); msg_ready = 1'b0;
        @(negedge clk);
        chk("R10 next source loaded", {31'b0, msg_valid} | (32'(msg_src) << 4), 32'h11);
        msg_ready = 1'b1; eoi_valid = 1'b1; eoi_src = 2'd0;
        @(negedge clk); msg_ready = 1'b0; eoi_valid = 1'b0;
        @(negedge clk);
        chk("R12 lower source offered again", {msg_valid, 23'b0, msg_vector}, {1'b1, 23'b0, 8'hA0});
        rd(2, d); chk("R12 accepted source waiting", d, lo_exp(mk_lo(0, 1, 0, 0, 3'd0, 8'hB1), 1'b1));
        rd(0, d); chk("R12 EOI source cleared", d, lo_exp(mk_lo(0, 1, 0, 0, 3'd0, 8'hA0), 1'b0));
        wr(0, mk_lo(1, 0, 0, 0, 3'd0, 8'hA0));
        wr(2, mk_lo(1, 0, 0, 0, 3'd0, 8'hB1));
        msg_ready = 1'b1;
        collect(4);

        // R10: random priority rounds
        for (int r = 0; r < 12; r++) begin
            logic [N-1:0] pol, msk, tgt, e;
            int exp_n, pos;
            pol = N'($urandom);
            msk = N'($urandom);
            tgt = N'($urandom);
            @(negedge clk); line = pol;
            repeat (4) @(negedge clk);
            for (int i = 0; i < N; i++) begin
                wr(2 * i, mk_lo(msk[i], 1, pol[i], 0, 3'd1, 8'h40 + 8'(i)));
            end
            collect(4);
            chk("R5 inactive lines silent", 32'(got_n), 32'd0);
            @(negedge clk); line = tgt;
            e = ~msk & (tgt ^ pol);
            collect(24);
            exp_n = $countones(e);
            chk("R10 message count", 32'(got_n), 32'(exp_n));
            pos = 0;
            for (int i = 0; i < N; i++) begin
                if (e[i] && pos < got_n) begin
                    chk("R10 ascending source", 32'(got_src[pos]), 32'(i));
                    chk("R10 vector of source", 32'(got_vec[pos]), 32'h40 + 32'(i));
                    pos++;
                end
            end
            for (int i = 0; i < N; i++) begin
                wr(2 * i, mk_lo(1, 0, 0, 0, 3'd0, 8'h00));
            end
            collect(4);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule